// File: doc/BRIEF.md
# Power-Down Hold and Idle Standby Controller

This block sits between the pads and the core logic. It gives the chip a low-power hold mode driven by one pin. A static configuration bit turns the feature on. While the feature is on, the power-down pin is a pure control input and the core never sees it as data. When the synchronised pin goes high, the block freezes three things together: the input values shown to the core, the output data sent to the pads and the per-pad output enables. Pins that were high-impedance at that point therefore stay high-impedance. Input activity has no effect on the core until the hold is released.

When the pin goes low again, the hold continues for a programmable number of clock cycles. After that, the block releases the frozen values and raises a valid flag. A separate idle monitor watches the raw input pins and raises a standby flag once the inputs have stayed unchanged for a programmable number of clock edges. The flag drops as soon as an edge samples a change.

Top module: `pdh_ctrl`

## Requirements
- R1: With `pd_feature_en` = 0, `core_pd_in` follows `pd_pin`. `core_in`, `pad_dout` and `pad_oe` follow `pin_in`, `core_dout` and `core_oe` in the same cycle, and no hold ever begins.
- R2: With `pd_feature_en` = 1, `core_pd_in` is 0 whatever `pd_pin` does.
- R3: `pd_pin` passes through a two-flop synchroniser. The hold begins at the second rising clock edge after `pd_pin` goes high. The values frozen are those present on `pin_in`, `core_dout` and `core_oe` at that edge. Before that edge all three pass through.
- R4: While holding, `core_in` keeps its frozen value and changes on `pin_in` have no effect on it.
- R5: While holding, `pad_dout` keeps its frozen value whatever `core_dout` does.
- R6: While holding, `pad_oe` keeps its frozen value (bit value 0 means that pad is high-impedance). A disabled pad stays disabled even if `core_oe` enables it. After release, `pad_oe` follows `core_oe` again.
- R7: The synchronised pin falls at the second edge after `pd_pin` goes low. The hold then lasts for `recov_cycles` further edges, and `out_valid` is 0 for the whole hold, including this recovery window. With `recov_cycles` = 0, `out_valid` returns at the edge where the synchroniser falls.
- R8: If the pin is raised again during the recovery window, the hold never lapses. The recovery count restarts in full after the next release.
- R9: `standby` rises at the edge that completes max(`idle_limit`,1) consecutive edges at which `pin_in` equalled its value at the previous edge.
- R10: `standby` is 0 after any edge at which `pin_in` differs from its value at the previous edge.
- R11: After reset, `out_valid` = 1, `standby` = 0 and all paths pass through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pd_feature_en | input | 1 | Static enable for the power-down function |
| pd_pin | input | 1 | Power-down pin, active high when enabled |
| pin_in | input | N_IN | Input pin values |
| core_dout | input | N_OUT | Output data from core logic |
| core_oe | input | N_OUT | Output enables from core logic (1 = drive) |
| recov_cycles | input | RECOV_W | Recovery window length in cycles |
| idle_limit | input | IDLE_W | Idle edges needed before standby |
| core_in | output | N_IN | Input values presented to core logic |
| core_pd_in | output | 1 | Power-down pin as a logic input (0 when feature on) |
| pad_dout | output | N_OUT | Output data to pads |
| pad_oe | output | N_OUT | Output enables to pads |
| out_valid | output | 1 | High when no hold or recovery is in progress |
| standby | output | 1 | Idle standby indication |

## Verification
A capture register that loads during a hold shows up at once, within a single cycle, as a step on `core_in`, `pad_dout` or `pad_oe` while `out_valid` is low. An off-by-one in the recovery counter moves the rise of `out_valid`, and the moment the pads follow the core again, by exactly one edge, so the release point is sampled on both sides. A stale idle count shows up as `standby` rising one edge early or late after a pin change, or failing to drop on the edge that sees the change.

// File: rtl/pdh_pkg.sv
package pdh_pkg;

  typedef enum logic [1:0] {
    PH_RUN     = 2'd0,
    PH_HOLD    = 2'd1,
    PH_RECOVER = 2'd2
  } pdh_phase_e;

  // Next value of the recovery counter: reload while the request is up,
  // otherwise count down to zero.
  function automatic logic [31:0] recov_step(input logic req,
                                             input logic [31:0] cnt,
                                             input logic [31:0] load);
    if (req)           return load;
    else if (cnt != 0) return cnt - 32'd1;
    else               return 32'd0;
  endfunction

  // Next value of the idle counter: clear on a change, saturate at limit.
  function automatic logic [31:0] idle_step(input logic chg,
                                            input logic [31:0] cnt,
                                            input logic [31:0] limit);
    if (chg)               return 32'd0;
    else if (cnt >= limit) return cnt;
    else                   return cnt + 32'd1;
  endfunction

  // Standby decision taken from the next idle count.
  function automatic logic idle_reached(input logic chg,
                                        input logic [31:0] nxt,
                                        input logic [31:0] limit);
    return !chg && (nxt == limit);
  endfunction

endpackage

// File: rtl/pdh_sync.sv
module pdh_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= STAGES'({chain, d});
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pdh_recover.sv
module pdh_recover
  import pdh_pkg::*;
#(
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pd_req,
  input  logic [RW-1:0] recov_cycles,
  output logic          hold_act,
  output logic          out_valid,
  output logic [RW-1:0] cnt
);
  logic [RW-1:0] cnt_nx;
  pdh_phase_e    phase;

  assign cnt_nx = RW'(recov_step(pd_req, 32'(cnt), 32'(recov_cycles)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nx;
  end

  always_comb begin
    if (pd_req)        phase = PH_HOLD;
    else if (cnt != 0) phase = PH_RECOVER;
    else               phase = PH_RUN;
  end

  assign hold_act  = (phase != PH_RUN);
  assign out_valid = (phase == PH_RUN);
endmodule

// File: rtl/pdh_freeze.sv
module pdh_freeze #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold,
  input  logic [W-1:0] live,
  output logic [W-1:0] shown
);
  logic [W-1:0] cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cap <= '0;
    else if (!hold) cap <= live;
  end

  assign shown = hold ? cap : live;
endmodule

// File: rtl/pdh_idle.sv
module pdh_idle
  import pdh_pkg::*;
#(
  parameter int W  = 8,
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  live,
  input  logic [IW-1:0] limit,
  output logic          standby,
  output logic          chg
);
  logic [W-1:0]  prev;
  logic [W-1:0]  diff;
  logic [IW-1:0] cnt;
  logic [IW-1:0] cnt_nx;

  for (genvar i = 0; i < W; i++) begin : g_diff
    assign diff[i] = live[i] ^ prev[i];
  end

  assign chg    = |diff;
  assign cnt_nx = IW'(idle_step(chg, 32'(cnt), 32'(limit)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev    <= '0;
      cnt     <= '0;
      standby <= 1'b0;
    end else begin
      prev    <= live;
      cnt     <= cnt_nx;
      standby <= idle_reached(chg, 32'(cnt_nx), 32'(limit));
    end
  end
endmodule

// File: rtl/pdh_ctrl.sv
module pdh_ctrl
  import pdh_pkg::*;
#(
  parameter int N_IN        = 8,
  parameter int N_OUT       = 8,
  parameter int RECOV_W     = 8,
  parameter int IDLE_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pd_feature_en,
  input  logic               pd_pin,
  input  logic [N_IN-1:0]    pin_in,
  input  logic [N_OUT-1:0]   core_dout,
  input  logic [N_OUT-1:0]   core_oe,
  input  logic [RECOV_W-1:0] recov_cycles,
  input  logic [IDLE_W-1:0]  idle_limit,
  output logic [N_IN-1:0]    core_in,
  output logic               core_pd_in,
  output logic [N_OUT-1:0]   pad_dout,
  output logic [N_OUT-1:0]   pad_oe,
  output logic               out_valid,
  output logic               standby
);
  // Named internal events, visible to the bound checker
  logic               pd_sync;
  logic               pd_req;
  logic               hold_act;
  logic               in_chg;
  logic [RECOV_W-1:0] rec_cnt;

  pdh_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pd_pin), .q(pd_sync)
  );

  assign pd_req     = pd_feature_en & pd_sync;
  assign core_pd_in = pd_feature_en ? 1'b0 : pd_pin;

  pdh_recover #(.RW(RECOV_W)) u_rec (
    .clk(clk), .rst_n(rst_n), .pd_req(pd_req), .recov_cycles(recov_cycles),
    .hold_act(hold_act), .out_valid(out_valid), .cnt(rec_cnt)
  );

  pdh_freeze #(.W(N_IN)) u_frz_in (
    .clk(clk), .rst_n(rst_n), .hold(hold_act), .live(pin_in), .shown(core_in)
  );

  pdh_freeze #(.W(N_OUT)) u_frz_dout (
    .clk(clk), .rst_n(rst_n), .hold(hold_act), .live(core_dout), .shown(pad_dout)
  );

  pdh_freeze #(.W(N_OUT)) u_frz_oe (
    .clk(clk), .rst_n(rst_n), .hold(hold_act), .live(core_oe), .shown(pad_oe)
  );

  pdh_idle #(.W(N_IN), .IW(IDLE_W)) u_idle (
    .clk(clk), .rst_n(rst_n), .live(pin_in), .limit(idle_limit),
    .standby(standby), .chg(in_chg)
  );
endmodule

// File: rtl/pdh_ctrl_chk.sv
module pdh_ctrl_chk #(
  parameter int N_IN    = 8,
  parameter int N_OUT   = 8,
  parameter int RECOV_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               pd_feature_en,
  input logic               pd_pin,
  input logic               pd_req,
  input logic               hold_act,
  input logic               in_chg,
  input logic [RECOV_W-1:0] rec_cnt,
  input logic [N_IN-1:0]    core_in,
  input logic               core_pd_in,
  input logic [N_OUT-1:0]   core_dout,
  input logic [N_OUT-1:0]   pad_dout,
  input logic [N_OUT-1:0]   pad_oe,
  input logic               out_valid,
  input logic               standby
);
  // R1
  pd_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_feature_en |-> core_pd_in == pd_pin);

  // R2
  pd_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd_feature_en |-> core_pd_in == 1'b0);

  // R4
  in_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_act && $past(hold_act) |-> $stable(core_in));

  // R5
  dout_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_act && $past(hold_act) |-> $stable(pad_dout));

  // R6
  oe_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_act && $past(hold_act) |-> $stable(pad_oe));

  // R7
  req_blocks_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd_req |-> !out_valid);

  // R7
  recov_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_req && rec_cnt != '0 |=> rec_cnt == $past(rec_cnt) - 1'b1);

  // R1
  valid_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> pad_dout == core_dout);

  // R10
  change_drops_stby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_chg |=> !standby);
endmodule

bind pdh_ctrl pdh_ctrl_chk #(
  .N_IN(N_IN), .N_OUT(N_OUT), .RECOV_W(RECOV_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pd_feature_en(pd_feature_en), .pd_pin(pd_pin),
  .pd_req(pd_req), .hold_act(hold_act), .in_chg(in_chg), .rec_cnt(rec_cnt),
  .core_in(core_in), .core_pd_in(core_pd_in), .core_dout(core_dout),
  .pad_dout(pad_dout), .pad_oe(pad_oe), .out_valid(out_valid), .standby(standby)
);

// File: tb/pdh_ctrl_test.sv
`timescale 1ns/1ps
module pdh_ctrl_test;
  localparam int K_IN = 0, K_DOUT = 1, K_OE = 2, K_VALID = 3, K_STBY = 4, K_PD = 5;

  typedef struct {
    int          cyc;
    int          kind;
    logic [31:0] exp;
    string       req;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pd_feature_en = 1'b0;
  logic        pd_pin = 1'b0;
  logic [7:0]  pin_in = '0;
  logic [7:0]  core_dout = '0;
  logic [7:0]  core_oe = '0;
  logic [7:0]  recov_cycles = 8'd3;
  logic [15:0] idle_limit = 16'd4;
  logic [7:0]  core_in;
  logic        core_pd_in;
  logic [7:0]  pad_dout;
  logic [7:0]  pad_oe;
  logic        out_valid;
  logic        standby;

  int    cyc = 0;
  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  item_t q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pdh_ctrl uut (
    .clk(clk), .rst_n(rst_n), .pd_feature_en(pd_feature_en), .pd_pin(pd_pin),
    .pin_in(pin_in), .core_dout(core_dout), .core_oe(core_oe),
    .recov_cycles(recov_cycles), .idle_limit(idle_limit),
    .core_in(core_in), .core_pd_in(core_pd_in), .pad_dout(pad_dout),
    .pad_oe(pad_oe), .out_valid(out_valid), .standby(standby)
  );

  function automatic logic [31:0] observe(input int k);
    case (k)
      K_IN:    return 32'(core_in);
      K_DOUT:  return 32'(pad_dout);
      K_OE:    return 32'(pad_oe);
      K_VALID: return 32'(out_valid);
      K_STBY:  return 32'(standby);
      default: return 32'(core_pd_in);
    endcase
  endfunction

  // Driver side: queue an expectation dly cycles ahead
  task automatic expect_at(input int dly, input int kind, input logic [31:0] exp,
                           input string req);
    item_t it;
    it.cyc  = cyc + dly;
    it.kind = kind;
    it.exp  = exp;
    it.req  = req;
    q.push_back(it);
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Monitor side: pop and compare at the falling edge
  always @(negedge clk) begin
    item_t       it;
    logic [31:0] act;
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      it  = q.pop_front();
      act = observe(it.kind);
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s kind=%0d cycle=%0d actual=%h expected=%h",
                 it.req, it.kind, cyc, act, it.exp);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog all actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R11 reset state
    expect_at(0, K_VALID, 1, "R11");
    expect_at(0, K_STBY, 0, "R11");
    expect_at(0, K_IN, 0, "R11");
    expect_at(0, K_DOUT, 0, "R11");

    // R1 feature off: plain passthrough, pd pin is data
    step(1);
    pin_in = 8'h5A; core_dout = 8'h3C; core_oe = 8'hF0; pd_pin = 1'b1;
    expect_at(0, K_IN, 32'h5A, "R1");
    expect_at(0, K_DOUT, 32'h3C, "R1");
    expect_at(0, K_OE, 32'hF0, "R1");
    expect_at(0, K_PD, 1, "R1");
    step(3);
    pin_in = 8'hA5;
    expect_at(0, K_IN, 32'hA5, "R1");
    expect_at(0, K_VALID, 1, "R1");
    pd_pin = 1'b0;
    step(3);

    // R2 feature on: pd pin hidden
    pd_feature_en = 1'b1;
    expect_at(0, K_PD, 0, "R2");
    step(1);
    pd_pin = 1'b1;
    expect_at(0, K_PD, 0, "R2");
    expect_at(0, K_VALID, 1, "R3");
    step(1);
    pin_in = 8'hC3;
    expect_at(0, K_IN, 32'hC3, "R3");
    expect_at(0, K_VALID, 1, "R3");
    step(1);
    // hold active now; captured C3 / 3C / F0
    pin_in = 8'hFF; core_dout = 8'h00; core_oe = 8'hFF;
    expect_at(0, K_IN, 32'hC3, "R3");
    expect_at(0, K_VALID, 0, "R7");
    expect_at(0, K_DOUT, 32'h3C, "R5");
    expect_at(0, K_OE, 32'hF0, "R6");
    step(5);
    expect_at(0, K_IN, 32'hC3, "R4");
    expect_at(0, K_DOUT, 32'h3C, "R5");
    expect_at(0, K_OE, 32'hF0, "R6");

    // R7 release with three recovery cycles
    pd_pin = 1'b0;
    expect_at(4, K_VALID, 0, "R7");
    expect_at(4, K_IN, 32'hC3, "R7");
    expect_at(5, K_VALID, 1, "R7");
    expect_at(5, K_IN, 32'hFF, "R7");
    expect_at(5, K_OE, 32'hFF, "R6");
    expect_at(5, K_DOUT, 32'h00, "R7");
    step(6);

    // R8 reassert during recovery
    pd_pin = 1'b1;
    step(3);
    pd_pin = 1'b0; pin_in = 8'h11;
    expect_at(0, K_IN, 32'hFF, "R8");
    step(3);
    pd_pin = 1'b1;
    expect_at(0, K_VALID, 0, "R8");
    expect_at(2, K_VALID, 0, "R8");
    step(3);
    pd_pin = 1'b0;
    expect_at(0, K_IN, 32'hFF, "R8");
    expect_at(4, K_VALID, 0, "R8");
    expect_at(5, K_VALID, 1, "R8");
    expect_at(5, K_IN, 32'h11, "R8");
    step(6);

    // R7 zero recovery length
    recov_cycles = 8'd0; pd_pin = 1'b1;
    step(4);
    pd_pin = 1'b0;
    expect_at(1, K_VALID, 0, "R7");
    expect_at(2, K_VALID, 1, "R7");
    step(3);

    // R9 / R10 idle standby, limit 4
    step(8);
    expect_at(0, K_STBY, 1, "R9");
    pin_in = 8'h33;
    expect_at(0, K_STBY, 1, "R10");
    expect_at(1, K_STBY, 0, "R10");
    expect_at(4, K_STBY, 0, "R9");
    expect_at(5, K_STBY, 1, "R9");
    step(6);
    idle_limit = 16'd0; pin_in = 8'h44;
    expect_at(1, K_STBY, 0, "R10");
    expect_at(2, K_STBY, 1, "R9");
    step(4);

    if (q.size() != 0) begin
      errors++;
      $display("FAIL queue all actual=%0d expected=0", q.size());
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule